// File: doc/BRIEF.md
# Quasi-Bidirectional Port Expander

This block is an I2C target that gives a host a bank of 8 or 16 port pins with no direction control. A single output latch is loaded over the bus. A latched 0 pulls its pin low. A latched 1 releases the pin to a weak pull-up, so the pin can then be driven by an outside source and read back as an input. Every read returns the live pin levels rather than the latch. The latch resets to all ones, so after reset every pin is released.

The 7-bit target address is a base (0x20 by default, or 0x38 for the alternate variant) ORed with three select pins. There are no command or pointer bytes. A write carries latch bytes and a read returns pin bytes. In the 16-pin variant, each access moves a pair of bytes, and pins 0 to 7 come first.

An active-low interrupt falls when the pins differ from the value captured at the last read. It clears when a read happens, or when the pins return to that captured value. SCL and SDA are synchronised to the system clock and filtered for glitches. START and STOP abandon any partial byte and send the target back to address matching.

Top module: `qbx_expander`

## Requirements
- R1: While rst_n is low, and after it rises, the latch is all ones: pin_pd is all zero, irq_n is 1 and sda_oe is 0.
- R2: The target acknowledges only the address ADDR_BASE | addr_sel, sent in the first byte after START as bits 7..1, with bit 0 = 0 for write and 1 for read. For any other address the target does not acknowledge, leaves SDA released and leaves the latch unchanged.
- R3: A write sets pin_pd to the complement of the written latch value. With 16 pins, the first data byte carries pins 7..0 and the second carries pins 15..8.
- R4: The latch changes only when the last byte of a group (one byte, or a byte pair with 16 pins) completes at its acknowledge. A partial byte, or a lone first byte of a pair, ended by STOP or START leaves the latch unchanged. The next transfer starts a new pair.
- R5: Further byte groups in the same write transaction keep updating the latch, each at its own acknowledge.
- R6: A read returns the pin levels, not the latch. A pin whose latch bit is 1 but which is held low from outside reads 0. With 16 pins, the first byte is pins 7..0 and the second is pins 15..8, both taken from one snapshot.
- R7: irq_n falls within a few clocks after the pin levels come to differ from the value captured at the last read.
- R8: irq_n returns high after a read captures the pins. It also returns high when the pins go back to the captured value.
- R9: During a read, a host ACK continues with the next byte group, taken from live pins. A host NACK releases SDA and ends the transfer.
- R10: Pulses on SCL or SDA shorter than FILT_CYCLES system clocks are ignored and do not alter the shifted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; holds latch and bus engine at default |
| scl_i | input | 1 | I2C clock level |
| sda_i | input | 1 | I2C data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_i | input | PIN_COUNT | Live pin levels |
| pin_pd | output | PIN_COUNT | 1 turns on the pull-down of a pin (latch bit is 0) |
| irq_n | output | 1 | Active-low pin change interrupt |

## Verification
The bench targets the cases where the quasi-bidirectional model is easy to get wrong:
- **Read source.** A pin that is latched high but pulled low from outside must read 0. A design that returns the latch would read it as 1.
- **Byte pairing.** A write cut short after one byte or partway through a byte must not move the latch, and the next pair must not come out shifted by one byte. A design that stores on each byte, or does not reset its pair index at STOP, fails these checks.
- **Interrupt behaviour.** The interrupt is checked both when the pins return to the captured value and when it is cleared by a read.
- **Glitch rejection.** A two-clock SCL pulse is injected in the middle of a byte; an unfiltered design would shift an extra bit.

// File: rtl/qbx_pkg.sv
package qbx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } qbx_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/qbx_glitch_filter.sv
module qbx_glitch_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("FILT_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          cnt_q;
   logic                   out_q;
   logic                   s;

   assign s      = sync_q[SYNC_STAGES-1];
   assign line_o = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         cnt_q  <= '0;
         out_q  <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         if (s == out_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
            out_q <= s;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q != $past(out_q)) |-> ($past(s) == out_q && $past(cnt_q) == CW'(FILT_CYCLES - 1))); // R10

endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
   import qbx_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE = 7'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic [2:0]        addr_sel,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              rd_req,
   output logic              xfer_rst
);
   qbx_state_e        state_q;
   logic              scl_q, sda_q;
   logic [3:0]        bit_cnt_q;
   logic [BYTE_W-1:0] sh_q, tx_q;
   logic              rw_q, mack_q, oe_q;
   logic [6:0]        my_addr;
   logic              scl_rise, scl_fall, start_c, stop_c;

   assign my_addr  = ADDR_BASE | {4'b0000, addr_sel};
   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_c  = scl & scl_q & sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q & sda;
   assign sda_oe   = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
         bit_cnt_q <= '0;
         sh_q      <= '0;
         tx_q      <= '1;
         rw_q      <= 1'b0;
         mack_q    <= 1'b0;
         oe_q      <= 1'b0;
         wr_stb    <= 1'b0;
         wr_byte   <= '0;
         rd_req    <= 1'b0;
         xfer_rst  <= 1'b0;
      end else begin
         scl_q    <= scl;
         sda_q    <= sda;
         wr_stb   <= 1'b0;
         rd_req   <= 1'b0;
         xfer_rst <= 1'b0;
         if (start_c) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
            xfer_rst  <= 1'b1;
         end else if (stop_c) begin
            state_q  <= ST_IDLE;
            oe_q     <= 1'b0;
            xfer_rst <= 1'b1;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     sh_q      <= {sh_q[BYTE_W-2:0], sda};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall && bit_cnt_q == 4'd8) begin
                     if (state_q == ST_ADDR) begin
                        if (sh_q[7:1] == my_addr) begin
                           oe_q    <= 1'b1;
                           rw_q    <= sh_q[0];
                           state_q <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        oe_q    <= 1'b1;
                        wr_stb  <= 1'b1;
                        wr_byte <= sh_q;
                        state_q <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bit_cnt_q <= '0;
                     if (rw_q) begin
                        tx_q    <= rd_byte;
                        rd_req  <= 1'b1;
                        oe_q    <= ~rd_byte[7];
                        state_q <= ST_RD;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     oe_q      <= 1'b0;
                     bit_cnt_q <= '0;
                     state_q   <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt_q == 4'd8) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RD_ACK;
                     end else begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
                        oe_q <= ~tx_q[6];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q      <= rd_byte;
                        rd_req    <= 1'b1;
                        oe_q      <= ~rd_byte[7];
                        bit_cnt_q <= '0;
                        state_q   <= ST_RD;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  oe_q <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !oe_q); // R2

   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb, rd_req})); // R3

   AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (oe_q && state_q == ST_WR_ACK)); // R4

   AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD_ACK && scl_fall && !mack_q && !start_c && !stop_c) |=> (state_q == ST_IDLE && !oe_q)); // R9

endmodule

// File: rtl/qbx_port.sv
module qbx_port
   import qbx_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] pins_raw,
   input  logic                 wr_stb,
   input  logic [BYTE_W-1:0]    wr_byte,
   input  logic                 rd_req,
   input  logic                 xfer_rst,
   output logic [PIN_COUNT-1:0] latch_o,
   output logic [BYTE_W-1:0]    rd_byte,
   output logic                 irq_n
);
   logic [PIN_COUNT-1:0] sync_q [SYNC_STAGES];
   logic [PIN_COUNT-1:0] pin_s;
   logic [PIN_COUNT-1:0] latch_q;
   logic [PIN_COUNT-1:0] ref_q;
   logic                 rd_first;
   logic                 irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
      end else begin
         sync_q[0] <= pins_raw;
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
   end
   assign pin_s = sync_q[SYNC_STAGES-1];

   if (PIN_COUNT == 8) begin : g_single
      assign rd_byte  = pin_s;
      assign rd_first = 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            latch_q <= '1;
            ref_q   <= '1;
         end else begin
            if (wr_stb) latch_q <= wr_byte;
            if (rd_req) ref_q <= pin_s;
         end
      end
   end else begin : g_pair
      logic              idx_q;
      logic [BYTE_W-1:0] lo_q;
      logic [BYTE_W-1:0] snap_hi_q;

      assign rd_first = ~idx_q;
      assign rd_byte  = idx_q ? snap_hi_q : pin_s[7:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            latch_q   <= '1;
            ref_q     <= '1;
            idx_q     <= 1'b0;
            lo_q      <= '1;
            snap_hi_q <= '1;
         end else if (xfer_rst) begin
            idx_q <= 1'b0;
         end else if (wr_stb) begin
            if (!idx_q) begin
               lo_q  <= wr_byte;
               idx_q <= 1'b1;
            end else begin
               latch_q <= {wr_byte, lo_q};
               idx_q   <= 1'b0;
            end
         end else if (rd_req) begin
            if (!idx_q) begin
               snap_hi_q <= pin_s[15:8];
               ref_q     <= pin_s;
               idx_q     <= 1'b1;
            end else begin
               idx_q <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (pin_s != ref_q);
   end

   assign irq_n   = ~irq_q;
   assign latch_o = latch_q;

   AST_LATCH_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q != $past(latch_q)) |-> $past(wr_stb)); // R4

   AST_READ_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_first && !xfer_rst) |=> (ref_q == $past(pin_s))); // R8

endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
   import qbx_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 16,
   parameter logic [6:0]  ADDR_BASE   = 7'h20,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_CYCLES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   input  logic [2:0]           addr_sel,
   input  logic [PIN_COUNT-1:0] pin_i,
   output logic [PIN_COUNT-1:0] pin_pd,
   output logic                 irq_n
);
   if (PIN_COUNT != 8 && PIN_COUNT != 16) begin : g_bad_pins
      $error("PIN_COUNT must be 8 or 16");
   end
   if (ADDR_BASE[2:0] != 3'b000) begin : g_bad_base
      $error("ADDR_BASE low three bits must be zero");
   end

   logic [1:0]           raw_lines;
   logic [1:0]           clean_lines;
   logic                 wr_stb, rd_req, xfer_rst;
   logic [BYTE_W-1:0]    wr_byte, rd_byte;
   logic [PIN_COUNT-1:0] latch;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      qbx_glitch_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_CYCLES(FILT_CYCLES)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[g]),
         .line_o(clean_lines[g])
      );
   end

   qbx_i2c_target #(
      .ADDR_BASE(ADDR_BASE)
   ) u_target (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl     (clean_lines[0]),
      .sda     (clean_lines[1]),
      .addr_sel(addr_sel),
      .rd_byte (rd_byte),
      .sda_oe  (sda_oe),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte),
      .rd_req  (rd_req),
      .xfer_rst(xfer_rst)
   );

   qbx_port #(
      .PIN_COUNT  (PIN_COUNT),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_raw(pin_i),
      .wr_stb  (wr_stb),
      .wr_byte (wr_byte),
      .rd_req  (rd_req),
      .xfer_rst(xfer_rst),
      .latch_o (latch),
      .rd_byte (rd_byte),
      .irq_n   (irq_n)
   );

   assign pin_pd = ~latch;

endmodule

// File: tb/sim_qbx_expander.sv
module sim_qbx_expander;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 10;
   localparam int NPINS      = 16;
   localparam logic [6:0] MY_ADDR = 7'h23;

   // each entry: {latch value to write, pins held low from outside}
   localparam logic [31:0] VEC [5] = '{
      {16'hA55A, 16'h0000},
      {16'h00FF, 16'h0000},
      {16'hFFFF, 16'h0F00},
      {16'h1234, 16'h0000},
      {16'hFFFF, 16'h8001}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             m_scl = 1'b1;
   logic             m_sda = 1'b1;
   logic [2:0]       addr_sel = 3'b011;
   logic [NPINS-1:0] ext_low = '0;
   logic             sda_oe, irq_n;
   logic [NPINS-1:0] pin_pd, pin_lvl;
   logic             bus_sda;
   int               n_chk = 0;
   int               n_fail = 0;
   bit               done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign bus_sda = m_sda & ~sda_oe;
   assign pin_lvl = ~pin_pd & ~ext_low;

   qbx_expander #(.PIN_COUNT(NPINS)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (m_scl),
      .sda_i   (bus_sda),
      .sda_oe  (sda_oe),
      .addr_sel(addr_sel),
      .pin_i   (pin_lvl),
      .pin_pd  (pin_pd),
      .irq_n   (irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start;
      m_sda = 1'b1; m_scl = 1'b1; wt(Q);
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic i2c_stop;
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b1; wt(Q);
      m_sda = 1'b1; wt(Q);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      m_sda = b;
      if (glitch) begin
         wt(3); m_scl = 1'b1; wt(2); m_scl = 1'b0; wt(Q - 5);
      end else begin
         wt(Q);
      end
      m_scl = 1'b1; wt(2 * Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1; wt(Q);
      b = bus_sda; wt(Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
      recv_bit(a);
      ack = !a;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         recv_bit(b);
         d[i] = b;
      end
      send_bit(!mack, 1'b0);
   endtask

   task automatic wr_pair(input logic [6:0] a, input logic [15:0] v, output bit ack);
      bit k;
      i2c_start;
      send_byte({a, 1'b0}, 1'b0, ack);
      send_byte(v[7:0], 1'b0, k);
      send_byte(v[15:8], 1'b0, k);
      i2c_stop;
   endtask

   task automatic rd_pair(output logic [15:0] v);
      bit k;
      i2c_start;
      send_byte({MY_ADDR, 1'b1}, 1'b0, k);
      recv_byte(1'b1, v[7:0]);
      recv_byte(1'b0, v[15:8]);
      i2c_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit          ack, k;
      logic [15:0] rv;
      logic [7:0]  b3;
      wt(5);
      chk("R1 pd in reset", {16'h0, pin_pd}, 32'h0);
      chk("R1 irq in reset", {31'h0, irq_n}, 32'h1);
      rst_n = 1'b1;
      wt(5);
      chk("R1 sda released", {31'h0, sda_oe}, 32'h0);

      // wrong address: no ack, latch untouched
      wr_pair(7'h27, 16'h0000, ack);
      chk("R2 foreign addr nack", {31'h0, ack}, 32'h0);
      chk("R2 foreign addr latch", {16'h0, pin_pd}, 32'h0);

      // table walk: write, check drive, read back live pins
      foreach (VEC[i]) begin
         ext_low = VEC[i][15:0];
         wr_pair(MY_ADDR, VEC[i][31:16], ack);
         if (i == 0) chk("R2 own addr ack", {31'h0, ack}, 32'h1);
         chk("R3 pull-downs", {16'h0, pin_pd}, {16'h0, ~VEC[i][31:16]});
         rd_pair(rv);
         chk("R6 read live pins", {16'h0, rv}, {16'h0, VEC[i][31:16] & ~VEC[i][15:0]});
         wt(6);
         chk("R8 irq after read", {31'h0, irq_n}, 32'h1);
      end

      // interrupt: pins 7FFE captured; release external pulls
      ext_low = 16'h0000; wt(10);
      chk("R7 irq on change", {31'h0, irq_n}, 32'h0);
      ext_low = 16'h8001; wt(10);
      chk("R8 irq on return", {31'h0, irq_n}, 32'h1);
      ext_low = 16'h0010; wt(10);
      chk("R7 irq on new change", {31'h0, irq_n}, 32'h0);
      rd_pair(rv);
      wt(6);
      chk("R8 irq cleared by read", {31'h0, irq_n}, 32'h1);
      ext_low = 16'h0000; wt(10);

      // partial transfers leave the latch (pins all released now)
      rd_pair(rv);
      i2c_start;
      send_byte({MY_ADDR, 1'b0}, 1'b0, k);
      for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
      i2c_stop;
      chk("R4 partial byte", {16'h0, pin_pd}, 32'h0);
      i2c_start;
      send_byte({MY_ADDR, 1'b0}, 1'b0, k);
      send_byte(8'h00, 1'b0, k);
      i2c_stop;
      chk("R4 lone first byte", {16'h0, pin_pd}, 32'h0);
      wr_pair(MY_ADDR, 16'hC3F0, ack);
      chk("R4 pairing after abort", {16'h0, pin_pd}, {16'h0, ~16'hC3F0});

      // repeated pairs in one write
      i2c_start;
      send_byte({MY_ADDR, 1'b0}, 1'b0, k);
      send_byte(8'h11, 1'b0, k);
      send_byte(8'h22, 1'b0, k);
      chk("R5 first pair", {16'h0, pin_pd}, {16'h0, ~16'h2211});
      send_byte(8'h44, 1'b0, k);
      send_byte(8'h88, 1'b0, k);
      i2c_stop;
      chk("R5 second pair", {16'h0, pin_pd}, {16'h0, ~16'h8844});

      // read continuation: third byte is next pair's low byte
      ext_low = 16'h0002;
      i2c_start;
      send_byte({MY_ADDR, 1'b1}, 1'b0, k);
      recv_byte(1'b1, rv[7:0]);
      recv_byte(1'b1, rv[15:8]);
      recv_byte(1'b0, b3);
      chk("R9 nack releases", {31'h0, sda_oe}, 32'h0);
      i2c_stop;
      chk("R9 pair read", {16'h0, rv}, {16'h0, 16'h8844 & ~16'h0002});
      chk("R9 continued byte", {24'h0, b3}, {24'h0, 8'h44 & ~8'h02});
      ext_low = 16'h0000;

      // glitched SCL inside every data bit
      i2c_start;
      send_byte({MY_ADDR, 1'b0}, 1'b0, k);
      send_byte(8'h5A, 1'b1, k);
      send_byte(8'h96, 1'b1, k);
      i2c_stop;
      chk("R10 glitch rejected", {16'h0, pin_pd}, {16'h0, ~16'h965A});

      // reset mid-operation
      wr_pair(MY_ADDR, 16'h0000, ack);
      rst_n = 1'b0; wt(4);
      chk("R1 reset clears latch", {16'h0, pin_pd}, 32'h0);
      rst_n = 1'b1; wt(6);
      chk("R1 irq after reset", {31'h0, irq_n}, 32'h1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule